// File: doc/BRIEF.md
# Keyboard Matrix Scan Port

This block provides two 8-bit bidirectional ports, called A and B. Each port has its own direction register, and together the ports scan an 8x8 active-low key matrix. A joystick also shares each port's lines. Software writes the port and direction registers to drive some lines low. It then reads the other port to see which keys sit where a driven line crosses a sensed line.

Scanning works both ways. In the normal direction, port A selects matrix rows and port B senses columns. In the reverse direction, port B selects columns and port A senses rows. Each joystick is folded into two paths:
- It acts as an extra driver on its port's lines.
- It acts as a mask on that port's read value.

A change detector watches bit 4 of the effective port B value and emits a one-cycle pulse when that bit changes, for use as a light-pen trigger.

The matrix and joystick states arrive on parallel buses and are registered every clock. Register reads are combinational from the stored state.

Top module: `kbd_scan_port`

## Requirements
- R1: After reset the port registers and both direction registers read 0. With no key pressed and joysticks idle (all ones), reads of offset 0 and offset 1 both return 0xFF.
- R2: Register offsets are 0 for port A data, 1 for port B data, 2 for A direction and 3 for B direction. A write is taken on the clock edge where `wr_en` is high. Offsets 2 and 3 read back the last value written. A direction bit of 1 makes that pin an output.
- R3: A read of offset 1 starts from the inverted B direction bits. For every line r where `((A data | ~A direction) & joy_on_a_n)` bit r is 0, it ANDs in matrix row r, which is `key_n[r*8 +: 8]` (0 = pressed).
- R4: A read of offset 1 then ORs in `(B data & B direction)`.
- R5: A read of offset 1 is finally ANDed with `joy_on_b_n`. A low bit of `joy_on_a_n` selects a matrix row exactly as a driven-low A line does.
- R6: A read of offset 0 starts from `(A data | ~A direction)`. For every column c where `((B data | ~B direction) & joy_on_b_n)` bit c is 0, it clears each bit r whose key `key_n[r*8+c]` is 0.
- R7: A read of offset 0 is finally ANDed with `joy_on_a_n`. A low bit of `joy_on_b_n` selects a column exactly as a driven-low B line does.
- R8: `key_n`, `joy_on_a_n` and `joy_on_b_n` are sampled on every clock edge. A change first shows in `rdata` after the next rising edge.
- R9: After a write to offset 1 or 3, `lp_pulse` is high for the one cycle that follows the write edge if bit 4 of `(B data | ~B direction)` differs from its value after the previous such write. Reset sets that previous value to 1.
- R10: Writes to offsets 0 and 2, cycles with no write, and writes to offset 1 or 3 that leave bit 4 of the effective B value unchanged all leave `lp_pulse` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register offset for read and write |
| wdata | input | 8 | Write data |
| key_n | input | 64 | Key matrix, bit r*8+c, 0 = pressed |
| joy_on_a_n | input | 8 | Joystick sharing port A lines, active low |
| joy_on_b_n | input | 8 | Joystick sharing port B lines, active low |
| rdata | output | 8 | Combinational read data for `addr` |
| lp_pulse | output | 1 | One-cycle light-pen trigger |

## Verification
A wrong data or direction register shows up on the very next read of either port. It also corrupts the drive pattern that selects rows or columns, so a single bad bit spreads into the other port's sense value once the right keys are pressed. A stale sampled matrix or joystick value lags the inputs by more than the one edge allowed, which a read placed right after a single edge exposes. A wrong remembered bit 4 stays hidden until the next write to offset 1 or 3, where it gives a missing or extra `lp_pulse` in the cycle after that write edge.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
    typedef enum logic [1:0] {
        ADDR_A_DATA = 2'd0,
        ADDR_B_DATA = 2'd1,
        ADDR_A_DIR  = 2'd2,
        ADDR_B_DIR  = 2'd3
    } kbd_addr_e;
endpackage

// File: rtl/kbd_port_regs.sv
module kbd_port_regs
    import kbd_scan_pkg::*;
#(
    parameter int unsigned W      = 8,
    parameter int unsigned LP_BIT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] a_data_q,
    output logic [W-1:0] b_data_q,
    output logic [W-1:0] a_dir_q,
    output logic [W-1:0] b_dir_q,
    output logic         lp_pulse_q
);
    typedef struct packed {
        logic [W-1:0] a_data;
        logic [W-1:0] b_data;
        logic [W-1:0] a_dir;
        logic [W-1:0] b_dir;
        logic         lp_prev;
        logic         lp_pulse;
    } regs_t;

    regs_t        s_d, s_q;
    logic [W-1:0] eff_b_d;

    always_comb begin
        s_d          = s_q;
        s_d.lp_pulse = 1'b0;
        if (wr_en) begin
            case (kbd_addr_e'(addr))
                ADDR_A_DATA: s_d.a_data = wdata;
                ADDR_B_DATA: s_d.b_data = wdata;
                ADDR_A_DIR:  s_d.a_dir  = wdata;
                ADDR_B_DIR:  s_d.b_dir  = wdata;
                default:     s_d = s_q;
            endcase
        end
        eff_b_d = s_d.b_data | ~s_d.b_dir;
        if (wr_en && addr[0]) begin
            s_d.lp_pulse = (eff_b_d[LP_BIT] != s_q.lp_prev);
            s_d.lp_prev  = eff_b_d[LP_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.lp_prev  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign a_data_q   = s_q.a_data;
    assign b_data_q   = s_q.b_data;
    assign a_dir_q    = s_q.a_dir;
    assign b_dir_q    = s_q.b_dir;
    assign lp_pulse_q = s_q.lp_pulse;
endmodule

// File: rtl/kbd_input_sampler.sv
module kbd_input_sampler #(
    parameter int unsigned W = 8,
    localparam int unsigned KEYS = W * W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [KEYS-1:0] key_n,
    input  logic [W-1:0]    joy_a_n,
    input  logic [W-1:0]    joy_b_n,
    output logic [KEYS-1:0] rows_q,
    output logic [KEYS-1:0] cols_q,
    output logic [W-1:0]    joy_a_q,
    output logic [W-1:0]    joy_b_q
);
    typedef struct packed {
        logic [KEYS-1:0] keys;
        logic [W-1:0]    joy_a;
        logic [W-1:0]    joy_b;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d.keys  = key_n;
        s_d.joy_a = joy_a_n;
        s_d.joy_b = joy_b_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign rows_q  = s_q.keys;
    assign joy_a_q = s_q.joy_a;
    assign joy_b_q = s_q.joy_b;

    for (genvar r = 0; r < W; r++) begin : g_row
        for (genvar c = 0; c < W; c++) begin : g_col
            assign cols_q[c*W + r] = s_q.keys[r*W + c];
        end
    end
endmodule

// File: rtl/kbd_read_combine.sv
module kbd_read_combine
    import kbd_scan_pkg::*;
#(
    parameter int unsigned W = 8,
    localparam int unsigned KEYS = W * W
) (
    input  logic [1:0]      addr,
    input  logic [W-1:0]    a_data,
    input  logic [W-1:0]    b_data,
    input  logic [W-1:0]    a_dir,
    input  logic [W-1:0]    b_dir,
    input  logic [KEYS-1:0] rows,
    input  logic [KEYS-1:0] cols,
    input  logic [W-1:0]    joy_a,
    input  logic [W-1:0]    joy_b,
    output logic [W-1:0]    rdata
);
    logic [W-1:0] drive_a, drive_b, sense_a, sense_b;

    always_comb begin
        drive_a = (a_data | ~a_dir) & joy_a;
        drive_b = (b_data | ~b_dir) & joy_b;

        sense_b = ~b_dir;
        for (int r = 0; r < W; r++) begin
            if (!drive_a[r]) sense_b = sense_b & rows[r*W +: W];
        end
        sense_b = (sense_b | (b_data & b_dir)) & joy_b;

        sense_a = a_data | ~a_dir;
        for (int c = 0; c < W; c++) begin
            if (!drive_b[c]) sense_a = sense_a & cols[c*W +: W];
        end
        sense_a = sense_a & joy_a;

        case (kbd_addr_e'(addr))
            ADDR_A_DATA: rdata = sense_a;
            ADDR_B_DATA: rdata = sense_b;
            ADDR_A_DIR:  rdata = a_dir;
            default:     rdata = b_dir;
        endcase
    end
endmodule

// File: rtl/kbd_scan_port.sv
module kbd_scan_port #(
    parameter int unsigned W      = 8,
    parameter int unsigned LP_BIT = 4,
    localparam int unsigned KEYS  = W * W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [W-1:0]    wdata,
    input  logic [KEYS-1:0] key_n,
    input  logic [W-1:0]    joy_on_a_n,
    input  logic [W-1:0]    joy_on_b_n,
    output logic [W-1:0]    rdata,
    output logic            lp_pulse
);
    logic [W-1:0]    a_data_q, b_data_q, a_dir_q, b_dir_q;
    logic [KEYS-1:0] rows_q, cols_q;
    logic [W-1:0]    joy_a_q, joy_b_q;

    kbd_port_regs #(.W(W), .LP_BIT(LP_BIT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .a_data_q   (a_data_q),
        .b_data_q   (b_data_q),
        .a_dir_q    (a_dir_q),
        .b_dir_q    (b_dir_q),
        .lp_pulse_q (lp_pulse)
    );

    kbd_input_sampler #(.W(W)) u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_n   (key_n),
        .joy_a_n (joy_on_a_n),
        .joy_b_n (joy_on_b_n),
        .rows_q  (rows_q),
        .cols_q  (cols_q),
        .joy_a_q (joy_a_q),
        .joy_b_q (joy_b_q)
    );

    kbd_read_combine #(.W(W)) u_rd (
        .addr   (addr),
        .a_data (a_data_q),
        .b_data (b_data_q),
        .a_dir  (a_dir_q),
        .b_dir  (b_dir_q),
        .rows   (rows_q),
        .cols   (cols_q),
        .joy_a  (joy_a_q),
        .joy_b  (joy_b_q),
        .rdata  (rdata)
    );
endmodule

// File: rtl/kbd_scan_port_chk.sv
module kbd_scan_port_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   addr,
    input logic [W-1:0] wdata,
    input logic [W-1:0] joy_on_a_n,
    input logic [W-1:0] joy_on_b_n,
    input logic [W-1:0] rdata,
    input logic         lp_pulse
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R9
    lp_needs_b_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lp_pulse |-> $past(wr_en && addr[0]));

    // R10
    lp_quiet_on_a_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr[0]) |=> !lp_pulse);

    // R2
    dir_a_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2) |=> (addr != 2'd2 || rdata == $past(wdata)));

    // R2
    dir_b_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3) |=> (addr != 2'd3 || rdata == $past(wdata)));

    // R5
    joy_b_masks_read_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (addr == 2'd1) |-> ((rdata & ~$past(joy_on_b_n)) == '0));

    // R7
    joy_a_masks_read_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (addr == 2'd0) |-> ((rdata & ~$past(joy_on_a_n)) == '0));
endmodule

bind kbd_scan_port kbd_scan_port_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .joy_on_a_n (joy_on_a_n),
    .joy_on_b_n (joy_on_b_n),
    .rdata      (rdata),
    .lp_pulse   (lp_pulse)
);

// File: tb/test_kbd_scan_port.sv
module test_kbd_scan_port;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [1:0]     addr = '0;
    logic [W-1:0]   wdata = '0;
    logic [W*W-1:0] key_n = '1;
    logic [W-1:0]   joy_on_a_n = '1;
    logic [W-1:0]   joy_on_b_n = '1;
    logic [W-1:0]   rdata;
    logic           lp_pulse;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [W-1:0] m_a, m_b, m_da, m_db;
    logic         m_prev;

    kbd_scan_port #(.W(W), .LP_BIT(4)) i_kbd_scan_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .key_n(key_n), .joy_on_a_n(joy_on_a_n), .joy_on_b_n(joy_on_b_n),
        .rdata(rdata), .lp_pulse(lp_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_b_read();
        logic [W-1:0] v, sel;
        v   = ~m_db;
        sel = (m_a | ~m_da) & joy_on_a_n;
        for (int r = 0; r < W; r++)
            if (!sel[r]) v = v & key_n[r*W +: W];
        return (v | (m_b & m_db)) & joy_on_b_n;
    endfunction

    function automatic logic [W-1:0] exp_a_read();
        logic [W-1:0] v, sel;
        v   = m_a | ~m_da;
        sel = (m_b | ~m_db) & joy_on_b_n;
        for (int c = 0; c < W; c++)
            if (!sel[c])
                for (int r = 0; r < W; r++)
                    if (!key_n[r*W + c]) v[r] = 1'b0;
        return v & joy_on_a_n;
    endfunction

    // Write one register; checks lp_pulse in the cycle after the edge (R9, R10).
    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        logic [W-1:0] eff;
        logic         exp_p;
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        case (a)
            2'd0: m_a = d;
            2'd1: m_b = d;
            2'd2: m_da = d;
            default: m_db = d;
        endcase
        exp_p = 1'b0;
        if (a[0]) begin
            eff   = m_b | ~m_db;
            exp_p = (eff[4] != m_prev);
            m_prev = eff[4];
        end
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check(exp_p ? "R9 pulse" : "R10 no pulse", {7'd0, lp_pulse}, {7'd0, exp_p});
    endtask

    task automatic read_all(input string tag);
        @(negedge clk);
        addr = 2'd0; #1; check({tag, " R6 R7 portA"}, rdata, exp_a_read());
        addr = 2'd1; #1; check({tag, " R3 R4 R5 portB"}, rdata, exp_b_read());
        addr = 2'd2; #1; check({tag, " R2 dirA"}, rdata, m_da);
        addr = 2'd3; #1; check({tag, " R2 dirB"}, rdata, m_db);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        m_a = '0; m_b = '0; m_da = '0; m_db = '0; m_prev = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        addr = 2'd0; #1; check("R1 portA", rdata, 8'hFF);
        addr = 2'd1; #1; check("R1 portB", rdata, 8'hFF);
        addr = 2'd2; #1; check("R1 dirA", rdata, 8'h00);
        addr = 2'd3; #1; check("R1 dirB", rdata, 8'h00);

        // R3 directed: drive row 2 low, key (2,5) pressed
        wr(2'd2, 8'hFF); wr(2'd0, 8'hFB);
        @(negedge clk); key_n = '1; key_n[2*8+5] = 1'b0;
        // R8: not yet visible before an edge
        addr = 2'd1; #1; check("R8 before edge", rdata, 8'hFF);
        @(posedge clk); @(negedge clk); #1;
        check("R8 R3 after edge", rdata, 8'hDF);

        // R9 / R10 directed pulses
        wr(2'd3, 8'h10);          // eff bit4 = 0 -> pulse
        wr(2'd3, 8'h10);          // unchanged -> none
        wr(2'd1, 8'h10);          // eff bit4 = 1 -> pulse
        wr(2'd0, 8'h00);          // A side -> none
        @(negedge clk); #1; check("R9 single cycle", {7'd0, lp_pulse}, 8'h00);

        // R5 / R7 directed: joystick on A selects row 0
        wr(2'd2, 8'h00); wr(2'd3, 8'h00);
        @(negedge clk); key_n = '1; key_n[0*8+3] = 1'b0; joy_on_a_n = 8'hFE;
        @(posedge clk); read_all("joyA");
        @(negedge clk); joy_on_a_n = '1; joy_on_b_n = 8'hF7;
        @(posedge clk); read_all("joyB");
        @(negedge clk); joy_on_b_n = '1;

        // Sweep
        for (int it = 0; it < 400; it++) begin
            logic [W*W-1:0] k;
            k = {$urandom, $urandom} | {$urandom, $urandom} | {$urandom, $urandom};
            wr(2'($urandom), 8'($urandom));
            wr(2'($urandom), 8'($urandom));
            wr(2'($urandom), 8'($urandom));
            @(negedge clk);
            key_n = k;
            joy_on_a_n = ($urandom % 4 == 0) ? ~(8'd1 << ($urandom % 8)) : 8'hFF;
            joy_on_b_n = ($urandom % 4 == 0) ? ~(8'd1 << ($urandom % 8)) : 8'hFF;
            @(posedge clk);
            read_all("sweep");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule